// File: doc/BRIEF.md
# Code Histogram Engine with External-Memory Read-Modify-Write

The block counts how often each converter output code occurs and keeps the counts in an external single-port memory, one word per bin. A start pulse first zeroes every bin, one word per cycle. Counting then begins. Each accepted sample is cut to the configured converter width and turned from two's complement into offset binary. The sample is mapped to a bin, and that bin's count is read, incremented and written back. The update occupies the engine for a fixed number of cycles, and samples that arrive during that time are lost. The loss does not matter for a distribution estimate, because the probability density survives the decimation.

Counting ends on the first write that brings any bin up to the selected ceiling. The engine then reads every bin in ascending address order and presents each one on a valid/ready output port together with its address. After the last bin it raises a completion flag. The converter width and the ceiling are latched when the start pulse is taken, so both selects may change while a run is in progress.

Top module: `hist_engine`

## Requirements
- R1: The width select `adc_wsel` sets the converter width to MAX_W - WSTEP*adc_wsel bits (18, 16, 14, 12 at defaults). Bits of `smp_code` above that width are ignored.
- R2: The most significant bit of the width-limited code is inverted before binning, so code 0 in two's complement maps to the middle of the range.
- R3: When the width exceeds BIN_W, the bin address is the top BIN_W bits of the offset-binary code. Otherwise the bin address is the code zero-extended. Bins that no code can reach stay at zero.
- R4: A start pulse writes zero to bins 0..2^BIN_W-1, one per cycle and in ascending order, before counting. Samples presented during this clear have no effect.
- R5: An accepted sample causes a read of its bin and, two cycles later, a write of the read value plus one to the same address. Read and write never share a cycle.
- R6: A sample is taken only when the engine is idle. After an accepted sample, the samples on the next SKIP cycles (11 at defaults) are dropped, so a valid held high counts exactly one sample in every SKIP+1.
- R7: Counting stops at the write whose value reaches the ceiling 2^(TGT_LOG - max_sel) (16384, 8192, 4096, 2048 at defaults). No count ever exceeds the ceiling, and later samples are ignored.
- R8: After counting stops, every bin is output in ascending address order on `out_bin`/`out_data`. A transfer happens on a cycle with `out_valid` and `out_ready` both high, and the data and address hold while the transfer is stalled.
- R9: `done` rises after the transfer of the last bin. It stays high with no memory access until the next start pulse, which clears it and begins a new run.
- R10: The width and ceiling selects are sampled only on the cycle a start pulse is taken. Changes during a run have no effect.
- R11: Out of reset, `done` and `out_valid` are low and no memory read or write is issued until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken when idle or finished) |
| adc_wsel | input | 2 | Converter width select |
| max_sel | input | 2 | Bin ceiling select |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | MAX_W | Converter code, LSB aligned |
| sram_addr | output | BIN_W | Memory address |
| sram_re | output | 1 | Memory read strobe (data returned next cycle) |
| sram_we | output | 1 | Memory write strobe |
| sram_wdata | output | CNT_W | Memory write data |
| sram_rdata | input | CNT_W | Memory read data |
| out_valid | output | 1 | Bin readout valid |
| out_ready | input | 1 | Bin readout accept |
| out_bin | output | BIN_W | Address of the bin being output |
| out_data | output | CNT_W | Count of the bin being output |
| done | output | 1 | Readout complete |

## Verification
The bench builds the engine with an 8-bit maximum width, 5-bit bins and a ceiling exponent of 4. This gives 32 bins and ceilings of 16, 8, 4 and 2, so every bin of every run is read back and compared. Each of the four width settings is exercised: the wide settings shift the code down into the bins, and the narrow ones leave the upper bins unreachable and therefore zero. The small ceilings let both a sparse sample stream and a continuous one reach termination within a few hundred cycles. The continuous stream pins down the one-in-twelve acceptance exactly, because the samples in the dropped slots carry codes that would alter the counts if they were taken.

// File: rtl/hist_pkg.sv
package hist_pkg;

  localparam int NUM_SEL = 4;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_CLR,
    ST_IDLE,
    ST_RD,
    ST_INC,
    ST_WR,
    ST_HOLD,
    ST_DRD,
    ST_DCAP,
    ST_DOUT,
    ST_DONE
  } hist_state_e;

endpackage

// File: rtl/hist_code_map.sv
module hist_code_map
  import hist_pkg::*;
#(
  parameter int MAX_W = 18,
  parameter int WSTEP = 2,
  parameter int BIN_W = 15
) (
  input  logic [MAX_W-1:0] raw,
  input  logic [1:0]       wsel,
  output logic [BIN_W-1:0] bin
);

  logic [BIN_W-1:0] cand [NUM_SEL];

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_width
    localparam int W  = MAX_W - WSTEP * g;
    localparam int SH = (W > BIN_W) ? (W - BIN_W) : 0;
    logic [W-1:0] fld;
    logic [W-1:0] offs;
    // limit to the converter width, then flip the sign bit
    assign fld  = raw[W-1:0];
    assign offs = {~fld[W-1], fld[W-2:0]};
    // keep the top bits when wide, zero-extend when narrow
    assign cand[g] = BIN_W'(offs >> SH);
  end

  assign bin = cand[wsel];

endmodule

// File: rtl/hist_limit.sv
module hist_limit
  import hist_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int TGT_LOG = 14
) (
  input  logic [1:0]       tsel,
  output logic [CNT_W-1:0] target
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] tab [NUM_SEL];

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tab
    assign tab[g] = ONE << (TGT_LOG - g);
  end

  assign target = tab[tsel];

endmodule

// File: rtl/hist_seq.sv
module hist_seq
  import hist_pkg::*;
#(
  parameter int BIN_W = 15,
  parameter int CNT_W = 24,
  parameter int SKIP  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             smp_valid,
  input  logic [BIN_W-1:0] smp_bin,
  input  logic [CNT_W-1:0] target,
  output logic             start_ack,
  output logic [BIN_W-1:0] sram_addr,
  output logic             sram_re,
  output logic             sram_we,
  output logic [CNT_W-1:0] sram_wdata,
  input  logic [CNT_W-1:0] sram_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BIN_W-1:0] out_bin,
  output logic [CNT_W-1:0] out_data,
  output logic             done,
  output logic             clearing,
  output logic             counting
);

  localparam int HOLD_N = SKIP - 3;
  localparam int HOLD_W = (HOLD_N > 1) ? $clog2(HOLD_N) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'((HOLD_N > 0) ? HOLD_N - 1 : 0);
  localparam logic [BIN_W-1:0]  LAST_BIN  = '1;
  localparam logic [CNT_W-1:0]  CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};

  hist_state_e      state_q, state_d;
  logic [BIN_W-1:0] ptr_q, ptr_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic [BIN_W-1:0] bin_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] out_q;
  logic             bin_en;
  logic             cnt_en;
  logic             out_en;
  logic             at_ceiling;

  assign at_ceiling = (cnt_q >= target);
  assign cnt_en     = (state_q == ST_INC);
  assign out_en     = (state_q == ST_DCAP);

  // next-state logic
  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    hold_d    = hold_q;
    start_ack = 1'b0;
    bin_en    = 1'b0;
    unique case (state_q)
      ST_OFF, ST_DONE: begin
        if (start) begin
          state_d   = ST_CLR;
          ptr_d     = '0;
          start_ack = 1'b1;
        end
      end
      ST_CLR: begin
        if (ptr_q == LAST_BIN) state_d = ST_IDLE;
        else                   ptr_d   = ptr_q + 1'b1;
      end
      ST_IDLE: begin
        if (smp_valid) begin
          state_d = ST_RD;
          bin_en  = 1'b1;
        end
      end
      ST_RD:  state_d = ST_INC;
      ST_INC: state_d = ST_WR;
      ST_WR: begin
        if (at_ceiling) begin
          state_d = ST_DRD;
          ptr_d   = '0;
        end else if (HOLD_N == 0) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_HOLD;
          hold_d  = '0;
        end
      end
      ST_HOLD: begin
        if (hold_q == HOLD_LAST) state_d = ST_IDLE;
        else                     hold_d  = hold_q + 1'b1;
      end
      ST_DRD:  state_d = ST_DCAP;
      ST_DCAP: state_d = ST_DOUT;
      ST_DOUT: begin
        if (out_ready) begin
          if (ptr_q == LAST_BIN) begin
            state_d = ST_DONE;
          end else begin
            ptr_d   = ptr_q + 1'b1;
            state_d = ST_DRD;
          end
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      ptr_q   <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      hold_q  <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
    end else if (bin_en) begin
      bin_q <= smp_bin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= sram_rdata + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= sram_rdata;
    end
  end

  // memory and output drive
  always_comb begin
    sram_we    = (state_q == ST_CLR) || (state_q == ST_WR);
    sram_re    = (state_q == ST_RD)  || (state_q == ST_DRD);
    sram_addr  = ((state_q == ST_CLR) || (state_q == ST_DRD)) ? ptr_q : bin_q;
    sram_wdata = (state_q == ST_WR) ? cnt_q : '0;
  end

  assign out_valid = (state_q == ST_DOUT);
  assign out_bin   = ptr_q;
  assign out_data  = out_q;
  assign done      = (state_q == ST_DONE);
  assign clearing  = (state_q == ST_CLR);
  assign counting  = (state_q == ST_RD) || (state_q == ST_INC) ||
                     (state_q == ST_WR) || (state_q == ST_HOLD);

endmodule

// File: rtl/hist_engine.sv
module hist_engine
  import hist_pkg::*;
#(
  parameter int MAX_W   = 18,
  parameter int WSTEP   = 2,
  parameter int BIN_W   = 15,
  parameter int CNT_W   = 24,
  parameter int TGT_LOG = 14,
  parameter int SKIP    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       adc_wsel,
  input  logic [1:0]       max_sel,
  input  logic             smp_valid,
  input  logic [MAX_W-1:0] smp_code,
  output logic [BIN_W-1:0] sram_addr,
  output logic             sram_re,
  output logic             sram_we,
  output logic [CNT_W-1:0] sram_wdata,
  input  logic [CNT_W-1:0] sram_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BIN_W-1:0] out_bin,
  output logic [CNT_W-1:0] out_data,
  output logic             done
);

  logic [1:0]       wsel_q;
  logic [1:0]       tsel_q;
  logic             start_ack;
  logic [BIN_W-1:0] smp_bin;
  logic [CNT_W-1:0] target;
  logic             clearing;
  logic             counting;

  // run configuration, captured when a start is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= '0;
      tsel_q <= '0;
    end else if (start_ack) begin
      wsel_q <= adc_wsel;
      tsel_q <= max_sel;
    end
  end

  hist_code_map #(
    .MAX_W (MAX_W),
    .WSTEP (WSTEP),
    .BIN_W (BIN_W)
  ) u_map (
    .raw  (smp_code),
    .wsel (wsel_q),
    .bin  (smp_bin)
  );

  hist_limit #(
    .CNT_W   (CNT_W),
    .TGT_LOG (TGT_LOG)
  ) u_limit (
    .tsel   (tsel_q),
    .target (target)
  );

  hist_seq #(
    .BIN_W (BIN_W),
    .CNT_W (CNT_W),
    .SKIP  (SKIP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .smp_valid  (smp_valid),
    .smp_bin    (smp_bin),
    .target     (target),
    .start_ack  (start_ack),
    .sram_addr  (sram_addr),
    .sram_re    (sram_re),
    .sram_we    (sram_we),
    .sram_wdata (sram_wdata),
    .sram_rdata (sram_rdata),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_bin    (out_bin),
    .out_data   (out_data),
    .done       (done),
    .clearing   (clearing),
    .counting   (counting)
  );

endmodule

// File: rtl/hist_engine_chk.sv
module hist_engine_chk #(
  parameter int BIN_W = 15,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [BIN_W-1:0] sram_addr,
  input logic             sram_re,
  input logic             sram_we,
  input logic [CNT_W-1:0] sram_wdata,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BIN_W-1:0] out_bin,
  input logic [CNT_W-1:0] out_data,
  input logic             done,
  input logic             clearing,
  input logic             counting,
  input logic [CNT_W-1:0] target
);

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_we && sram_re)); // R5

  AST_CLEAR_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> (sram_we && sram_wdata == '0)); // R4

  AST_RMW_SAME_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && sram_we) |-> ($past(sram_re, 2) && sram_addr == $past(sram_addr, 2))); // R5

  AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && sram_we) |-> (sram_wdata <= target)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_bin))); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !sram_we && !sram_re)); // R9

endmodule

bind hist_engine hist_engine_chk #(
  .BIN_W (BIN_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .sram_addr  (sram_addr),
  .sram_re    (sram_re),
  .sram_we    (sram_we),
  .sram_wdata (sram_wdata),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_bin    (out_bin),
  .out_data   (out_data),
  .done       (done),
  .clearing   (clearing),
  .counting   (counting),
  .target     (target)
);

// File: tb/hist_engine_tb.sv
`timescale 1ns/1ps
module hist_engine_tb;

  localparam int MAX_W   = 8;
  localparam int WSTEP   = 2;
  localparam int BIN_W   = 5;
  localparam int CNT_W   = 24;
  localparam int TGT_LOG = 4;
  localparam int SKIP    = 11;
  localparam int NB      = 1 << BIN_W;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [1:0]       adc_wsel;
  logic [1:0]       max_sel;
  logic             smp_valid;
  logic [MAX_W-1:0] smp_code;
  logic [BIN_W-1:0] sram_addr;
  logic             sram_re;
  logic             sram_we;
  logic [CNT_W-1:0] sram_wdata;
  logic [CNT_W-1:0] sram_rdata;
  logic             out_valid;
  logic             out_ready;
  logic [BIN_W-1:0] out_bin;
  logic [CNT_W-1:0] out_data;
  logic             done;

  logic [CNT_W-1:0] mem [NB];

  int checks;
  int fails;
  int wd;
  int expc [NB];
  bit hit;

  hist_engine #(
    .MAX_W (MAX_W), .WSTEP (WSTEP), .BIN_W (BIN_W),
    .CNT_W (CNT_W), .TGT_LOG (TGT_LOG), .SKIP (SKIP)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .start (start),
    .adc_wsel (adc_wsel), .max_sel (max_sel),
    .smp_valid (smp_valid), .smp_code (smp_code),
    .sram_addr (sram_addr), .sram_re (sram_re), .sram_we (sram_we),
    .sram_wdata (sram_wdata), .sram_rdata (sram_rdata),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_bin (out_bin), .out_data (out_data), .done (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // single-port memory model, one-cycle read latency, filled with junk in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 24'h5A0000 + CNT_W'(i * 3);
      sram_rdata <= '0;
    end else begin
      if (sram_we) mem[sram_addr] <= sram_wdata;
      if (sram_re) sram_rdata <= mem[sram_addr];
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", wd, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int width_of(input int ws);
    return MAX_W - WSTEP * ws;
  endfunction

  function automatic int bin_of(input int raw, input int ws);
    int w;
    int c;
    w = width_of(ws);
    c = raw & ((1 << w) - 1);
    c = c ^ (1 << (w - 1));
    if (w > BIN_W) c = c >> (w - BIN_W);
    return c;
  endfunction

  function automatic int mk_raw(input int code, input int salt, input int ws);
    int w;
    int junk;
    w    = width_of(ws);
    junk = ((salt * 13 + 1) << w) & ((1 << MAX_W) - 1);
    return (code & ((1 << w) - 1)) | junk;
  endfunction

  task automatic model_count(input int raw, input int ws, input int ts);
    int b;
    b = bin_of(raw, ws);
    if (!hit) begin
      expc[b]++;
      if (expc[b] == (1 << (TGT_LOG - ts))) hit = 1'b1;
    end
  endtask

  // start a run; samples shown during the clear must leave no trace (R4)
  task automatic do_start(input int ws, input int ts);
    @(negedge clk);
    adc_wsel = 2'(ws);
    max_sel  = 2'(ts);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < NB; i++) expc[i] = 0;
    hit = 1'b0;
    chk(done == 1'b0, "R9 done cleared by start", done, 0);
    for (int k = 0; k < 20; k++) begin
      smp_valid = 1'b1;
      smp_code  = MAX_W'(k * 11 + 3);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  // sparse samples, each one counted, plus three after termination (R7)
  task automatic feed_spaced(input int ws, input int ts, input int seed);
    int extra;
    int i;
    int raw;
    extra = 0;
    i = 0;
    while (extra < 3 && i < 4000) begin
      raw = mk_raw(i * 7 + seed, i, ws);
      smp_valid = 1'b1;
      smp_code  = MAX_W'(raw);
      @(negedge clk);
      smp_valid = 1'b0;
      if (hit) extra++;
      model_count(raw, ws, ts);
      repeat (SKIP + 1) @(negedge clk);
      i++;
    end
  endtask

  // valid held high: only every (SKIP+1)-th sample is counted (R6)
  task automatic feed_stream(input int ws, input int ts, input int n, input int seed);
    int raw;
    for (int j = 0; j < n; j++) begin
      if (j % (SKIP + 1) == 0) begin
        raw = mk_raw(((j / (SKIP + 1)) % 5) * 9 + seed, j, ws);
        model_count(raw, ws, ts);
      end else begin
        raw = (j * 31 + 17) & ((1 << MAX_W) - 1);
      end
      smp_valid = 1'b1;
      smp_code  = MAX_W'(raw);
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int idx;
    int cyc;
    bit stall;
    logic [CNT_W-1:0] pd;
    logic [BIN_W-1:0] pb;
    idx = 0;
    cyc = 0;
    stall = 1'b0;
    pd = '0;
    pb = '0;
    chk(done == 1'b0, "R9 done low before readout", done, 0);
    while (idx < NB && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (stall) begin
        chk(out_valid == 1'b1 && out_data == pd && out_bin == pb,
            "R8 output held while stalled", out_data, pd);
      end
      out_ready = ((cyc % 3) != 1);
      if (out_valid) begin
        if (out_ready) begin
          chk(out_bin == BIN_W'(idx), "R8 ascending bin order", out_bin, idx);
          chk(out_data == CNT_W'(expc[idx]), tag, out_data, expc[idx]);
          idx++;
          stall = 1'b0;
        end else begin
          stall = 1'b1;
          pd = out_data;
          pb = out_bin;
        end
      end else begin
        stall = 1'b0;
      end
    end
    chk(idx == NB, "R7 readout of all bins", idx, NB);
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R9 done after last bin", done, 1);
    chk(out_valid == 1'b0, "R9 no valid once done", out_valid, 0);
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R9 done held", done, 1);
  endtask

  initial begin
    checks    = 0;
    fails     = 0;
    wd        = 0;
    hit       = 1'b0;
    rst_n     = 1'b0;
    start     = 1'b0;
    adc_wsel  = '0;
    max_sel   = '0;
    smp_valid = 1'b0;
    smp_code  = '0;
    out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: quiet after reset, samples without a start do nothing
    chk(done == 1'b0, "R11 done low after reset", done, 0);
    chk(out_valid == 1'b0, "R11 out_valid low after reset", out_valid, 0);
    smp_valid = 1'b1;
    smp_code  = 8'h42;
    repeat (6) begin
      @(negedge clk);
      chk(sram_we == 1'b0 && sram_re == 1'b0, "R11 no memory access before start",
          {sram_we, sram_re}, 0);
    end
    smp_valid = 1'b0;

    // full width, shifted into bins, smallest ceiling
    do_start(0, 3);
    feed_spaced(0, 3, 5);
    drain("R1 R2 R3 R4 R5 full-width bin count");

    // 6-bit width, continuous stream; selects changed mid-run (R10)
    do_start(1, 2);
    adc_wsel = 2'd3;
    max_sel  = 2'd0;
    feed_stream(1, 2, 400, 2);
    drain("R6 R10 stream count at 6-bit width");

    // 4-bit width: zero-extended, upper bins unreachable
    do_start(2, 1);
    feed_spaced(2, 1, 1);
    drain("R1 R3 R4 R5 narrow-width bin count");

    // 2-bit width, largest ceiling, continuous stream
    do_start(3, 0);
    feed_stream(3, 0, 1200, 0);
    drain("R6 R7 stream count at 2-bit width");

    summary();
    $finish;
  end

endmodule